// File: doc/BRIEF.md
# Per-Tile Palette Substitution Latch

This block sits between the video address bus, the video read strobe and the data returned by the on-chip nametable memory. Its job is to remove the separate attribute table from the display path. On every read of a tile number from a nametable, it records the two most significant bits of that tile byte. On the attribute read that follows, it keeps the memory off the bus and drives the recorded pair instead, so the palette of each tile comes from its own tile number.

Decoding is combinational from the address and the active-low read strobe. The two-bit register loads on the clock edge that closes a nametable read and keeps its value through every other kind of access. The value is copied into all four two-bit fields of the substituted byte, so the result does not depend on which quadrant the renderer picks.

Top module: `tile_attr_sub`

## Requirements
- R1: Synchronous active-low reset clears the palette register to 0, so an attribute read right after reset drives 0x00.
- R2: A nametable read is rd_n low with an address in 0x2000-0x2FFF whose low 10 bits are below 0x3C0. During it, ram_en is 1, latch_oe is 0 and dout equals ram_data.
- R3: An attribute read is rd_n low with an address in 0x2000-0x2FFF whose low 10 bits are 0x3C0-0x3FF. During it, ram_en is 0 and latch_oe is 1, so memory data is not used.
- R4: On the rising clock edge at the end of a nametable read, ram_data bits 7 and 6 are loaded into the palette register.
- R5: During an attribute read, dout carries the palette value P in each of bits [7:6], [5:4], [3:2] and [1:0], so P=1 gives 0x55, P=2 gives 0xAA and P=3 gives 0xFF.
- R6: The palette register keeps its value across every cycle that is not a nametable read. This covers pattern reads, attribute reads, reads at 0x3000 or above, and nametable addresses with rd_n high.
- R7: When rd_n is high, or the address is outside 0x2000-0x2FFF, ram_en and latch_oe are 0 and dout is 0x00.
- R8: The class boundaries are exact: 0x23BF is a nametable read, 0x23C0 and 0x2FFF are attribute reads, and 0x1FFF and 0x3000 are neither.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vaddr | input | 14 | Video address bus |
| rd_n | input | 1 | Video read strobe, active low |
| ram_data | input | 8 | Data returned by the on-chip nametable memory |
| ram_en | output | 1 | Enables the on-chip nametable memory onto the bus |
| latch_oe | output | 1 | Enables the palette register onto the bus |
| dout | output | 8 | Data presented to the video bus |

## Verification
The assertions check four rules on every cycle. The memory enable and the latch enable are never both high. An enabled memory passes its data through unchanged. Each substituted byte is the replicated register value. The register loads only after a nametable read and holds at all other times. The bench scenarios cover what a single-cycle rule cannot show: the exact address boundaries between the classes, the value seen after reset, and one tile's upper bits reappearing on a later attribute read after pattern reads, idle strobes and out-of-window reads have come in between.

// File: rtl/tas_pkg.sv
// Package: shared types for the per-tile palette substitution latch.
// Assumes nothing beyond standard SystemVerilog.
package tas_pkg;
    // Class of the current video access
    typedef enum logic [1:0] {
        FETCH_NONE = 2'd0,
        FETCH_NAME = 2'd1,
        FETCH_ATTR = 2'd2
    } fetch_e;
endpackage

// File: rtl/tas_fetch_decode.sv
// Module: tas_fetch_decode
// Sorts each access into nametable read, attribute read or neither.
// The address and read strobe are used as they are, with no registering.
// Assumes the nametable window is aligned to 2**WIN_BITS and split into
// 2**(WIN_BITS-PAGE_BITS) pages, each with its attribute area at the top.
module tas_fetch_decode
    import tas_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int WIN_BITS  = 12,
    parameter int PAGE_BITS = 10,
    parameter int NT_BASE   = 'h2000,
    parameter int ATTR_OFS  = 'h3C0
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              rd_n,
    output fetch_e            fetch
);
    localparam int NUM_PAGES = 1 << (WIN_BITS - PAGE_BITS);
    localparam int SEL_W     = WIN_BITS - PAGE_BITS;
    localparam int TOP_W     = ADDR_W - WIN_BITS;

    logic                 in_window;
    logic [NUM_PAGES-1:0] page_hit;
    logic                 in_attr_area;

    // Window match on the address bits above the window size
    assign in_window = (vaddr[ADDR_W-1:WIN_BITS] == TOP_W'(NT_BASE >> WIN_BITS));

    // One-hot page select inside the window
    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        assign page_hit[p] = in_window &&
                             (vaddr[WIN_BITS-1:PAGE_BITS] == SEL_W'(p));
    end

    // Offset inside the page at or above the attribute area
    assign in_attr_area = (vaddr[PAGE_BITS-1:0] >= PAGE_BITS'(ATTR_OFS));

    // Final classification, active only while the strobe is low
    always_comb begin
        fetch = FETCH_NONE;
        if (!rd_n && (|page_hit)) begin
            fetch = in_attr_area ? FETCH_ATTR : FETCH_NAME;
        end
    end
endmodule

// File: rtl/tas_pal_latch.sv
// Module: tas_pal_latch
// Holds the palette bits taken from the top of the most recent tile byte.
// Loads only on cycles classed as nametable reads and holds otherwise.
// Assumes a synchronous active-low reset.
module tas_pal_latch
    import tas_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fetch_e            fetch,
    input  logic [DATA_W-1:0] tile_byte,
    output logic [PAL_W-1:0]  pal_q
);
    // Capture the upper tile bits at the end of a nametable read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pal_q <= '0;
        end else if (fetch == FETCH_NAME) begin
            pal_q <= tile_byte[DATA_W-1 -: PAL_W];
        end
    end
endmodule

// File: rtl/tas_bus_mux.sv
// Module: tas_bus_mux
// Produces the two bus enables and the byte driven to the video bus.
// On an attribute read the palette value is copied into every field.
// Assumes DATA_W is a multiple of PAL_W.
module tas_bus_mux
    import tas_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAL_W  = 2
) (
    input  fetch_e            fetch,
    input  logic [DATA_W-1:0] ram_data,
    input  logic [PAL_W-1:0]  pal_q,
    output logic              ram_en,
    output logic              latch_oe,
    output logic [DATA_W-1:0] dout
);
    localparam int FIELDS = DATA_W / PAL_W;

    logic [DATA_W-1:0] pal_byte;

    // Copy the palette value into each field of the substituted byte
    for (genvar f = 0; f < FIELDS; f++) begin : g_field
        assign pal_byte[f*PAL_W +: PAL_W] = pal_q;
    end

    // Pick the bus source from the access class
    always_comb begin
        ram_en   = 1'b0;
        latch_oe = 1'b0;
        dout     = '0;
        unique case (fetch)
            FETCH_NAME: begin
                ram_en = 1'b1;
                dout   = ram_data;
            end
            FETCH_ATTR: begin
                latch_oe = 1'b1;
                dout     = pal_byte;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tile_attr_sub.sv
// Module: tile_attr_sub
// Top of the per-tile palette substitution latch. It records the upper bits
// of each tile number and replays them in place of attribute data.
// Assumes a video address that is stable for each clock cycle and an
// active-low read strobe.
module tile_attr_sub
    import tas_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int DATA_W    = 8,
    parameter int PAL_W     = 2,
    parameter int WIN_BITS  = 12,
    parameter int PAGE_BITS = 10,
    parameter int NT_BASE   = 'h2000,
    parameter int ATTR_OFS  = 'h3C0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] ram_data,
    output logic              ram_en,
    output logic              latch_oe,
    output logic [DATA_W-1:0] dout
);
    fetch_e           fetch;
    logic [PAL_W-1:0] pal_q;

    // Access classification
    tas_fetch_decode #(
        .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .PAGE_BITS(PAGE_BITS),
        .NT_BASE(NT_BASE), .ATTR_OFS(ATTR_OFS)
    ) u_decode (
        .vaddr(vaddr), .rd_n(rd_n), .fetch(fetch)
    );

    // Palette register
    tas_pal_latch #(.DATA_W(DATA_W), .PAL_W(PAL_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .fetch(fetch),
        .tile_byte(ram_data), .pal_q(pal_q)
    );

    // Bus source selection
    tas_bus_mux #(.DATA_W(DATA_W), .PAL_W(PAL_W)) u_mux (
        .fetch(fetch), .ram_data(ram_data), .pal_q(pal_q),
        .ram_en(ram_en), .latch_oe(latch_oe), .dout(dout)
    );
endmodule

// File: rtl/tas_checker.sv
// Module: tas_checker
// Cycle-by-cycle rules for tile_attr_sub, attached with bind below.
module tas_checker #(
    parameter int DATA_W = 8,
    parameter int PAL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_n,
    input logic [DATA_W-1:0] ram_data,
    input logic              ram_en,
    input logic              latch_oe,
    input logic [DATA_W-1:0] dout,
    input logic [PAL_W-1:0]  pal_q
);
    localparam int FIELDS = DATA_W / PAL_W;

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_en && latch_oe)); // R3

    AST_RAM_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> (dout == ram_data)); // R2

    AST_PAL_REPLICA: assert property (@(posedge clk) disable iff (!rst_n)
        latch_oe |-> (dout == {FIELDS{pal_q}})); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> (!ram_en && !latch_oe && dout == '0)); // R7

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |=> (pal_q == $past(ram_data[DATA_W-1 -: PAL_W]))); // R4

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_en |=> $stable(pal_q)); // R6
endmodule

bind tile_attr_sub tas_checker #(.DATA_W(DATA_W), .PAL_W(PAL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .ram_data(ram_data),
    .ram_en(ram_en), .latch_oe(latch_oe), .dout(dout), .pal_q(pal_q)
);

// File: tb/tb_tile_attr_sub.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected bus results, the monitor
// compares them between clock edges.
module tb_tile_attr_sub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] vaddr = '0;
    logic        rd_n = 1'b1;
    logic [7:0]  ram_data = '0;
    logic        ram_en, latch_oe;
    logic [7:0]  dout;

    typedef struct {
        logic       en;
        logic       oe;
        logic [7:0] d;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    int         n_cmp = 0;
    int         n_bad = 0;
    logic [1:0] model_pal = 2'd0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    tile_attr_sub dut (
        .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .rd_n(rd_n),
        .ram_data(ram_data), .ram_en(ram_en), .latch_oe(latch_oe), .dout(dout)
    );

    // Drive one access and push the outcome the requirements predict
    task automatic access(input logic [13:0] a, input logic r_n,
                          input logic [7:0] d, input string tag);
        exp_t e;
        logic win, attr;
        @(negedge clk);
        vaddr = a; rd_n = r_n; ram_data = d;
        win  = (a >= 14'h2000) && (a <= 14'h2FFF);
        attr = (a[9:0] >= 10'h3C0);
        e.tag = tag;
        e.en = 1'b0; e.oe = 1'b0; e.d = 8'h00;
        if (!r_n && win && !attr) begin
            e.en = 1'b1; e.d = d;
        end else if (!r_n && win && attr) begin
            e.oe = 1'b1; e.d = {4{model_pal}};
        end
        sb.push_back(e);
        if (e.en) model_pal = d[7:6];
    endtask

    // Monitor: compare the settled outputs against the queue head
    always @(negedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            if (ram_en !== e.en || latch_oe !== e.oe || dout !== e.d) begin
                n_bad++;
                $display("FAIL %s: got en=%b oe=%b d=%h expected en=%b oe=%b d=%h",
                         e.tag, ram_en, latch_oe, dout, e.en, e.oe, e.d);
            end
        end
    end

    // Watchdog
    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: palette cleared by reset
        access(14'h23C0, 1'b0, 8'hFF, "R1");
        // R2 and R4: nametable read passes memory data and loads 3
        access(14'h2000, 1'b0, 8'hC5, "R2");
        // R3 and R5: attribute read substitutes 0xFF
        access(14'h23C0, 1'b0, 8'h12, "R3");
        access(14'h2400, 1'b0, 8'h7A, "R4");
        access(14'h27FF, 1'b0, 8'h00, "R5");
        // R6 and R7: non-nametable accesses leave the palette alone
        access(14'h0123, 1'b0, 8'hC0, "R7");
        access(14'h2BC8, 1'b0, 8'h00, "R6");
        access(14'h2100, 1'b1, 8'h80, "R7");
        access(14'h2BC8, 1'b0, 8'h00, "R6");
        access(14'h3000, 1'b0, 8'hFF, "R8");
        access(14'h2FFF, 1'b0, 8'h00, "R8");
        // R8: exact class boundaries
        access(14'h23BF, 1'b0, 8'h80, "R8");
        access(14'h23C0, 1'b0, 8'h00, "R8");
        access(14'h1FFF, 1'b0, 8'h40, "R8");
        access(14'h2FC0, 1'b0, 8'h00, "R6");
        // R5: every palette value replicated
        for (int i = 0; i < 4; i++) begin
            access(14'h2800 + 14'(i), 1'b0, {2'(i), 6'h15}, "R4");
            access(14'h2BC0 + 14'(i), 1'b0, 8'h3C, "R5");
        end
        access(14'h0000, 1'b1, 8'h00, "R7");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule